// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel Sequencer

This block runs one DMA channel that works through a linked list of transfer descriptors in memory. Software fills in descriptors and writes the address of the first one into the channel. It then raises the start bit in the mode register. The channel fetches each descriptor and copies its payload one 32-bit word at a time, as read/write pairs on a request/acknowledge memory port. It then follows the descriptor's next-link pointer. This repeats until it finishes a descriptor whose link word carries the end-of-list flag.

A descriptor is four words at a 32-byte aligned address:
- offset 0: source address
- offset 4: destination address
- offset 8: next link, where bit 0 is the end-of-list flag and bits 31:5 are the next descriptor address
- offset 12: byte count, in the low `CNT_W` bits

The status register gathers completion and error events. These bits are write-one-to-clear. It also shows the busy and halted state. A single interrupt line combines the events that software has enabled. Software can abort a running chain, or stop it by clearing the start bit. In either case the channel halts at the next memory-access boundary.

Register word addresses on `regAddr` are: 0 mode, 1 status, 2 current descriptor address, 3 remaining byte count. The register read data is combinational from `regAddr`.

Top module: `dma_seq_chan`

## Requirements
- R1: After reset the mode, status, current-descriptor and count registers read zero, `irq` is low and `memReq` is low.
- R2: Start begins when mode bit 0 is written from 0 to 1 while the channel is not busy. The channel then reads the four descriptor words at offsets 0, 4, 8 and 12 from the current-descriptor address. Next it moves the payload as read-from-source, write-to-destination word pairs, with both addresses rising by 4 each time. A final partial word is moved as a whole word. `memReq` stays high with a stable address until `memAck`.
- R3: Status bit 4 (busy) is set from the start until the last write of the end-of-list descriptor, or until a halt. The channel counts as idle when busy is clear or status bit 5 (halted) is set.
- R4: The channel follows next-link pointers through a chain. Each finished descriptor sets status bit 1, and the end-of-list descriptor also sets status bit 0. Afterwards the current-descriptor register reads the end-of-list descriptor's address and the count register reads 0.
- R5: Mode bit 0 stays set after a chain completes. Writing 1 to it while it is already 1 starts nothing. Clearing it and then setting it starts a new run.
- R6: Status bits 0 to 3 clear only when a 1 is written to them. Written zeros leave them unchanged.
- R7: A descriptor with a zero byte count sets status bit 2 (programming error) and moves no data. The count register then reads 0, and the chain continues or ends as its link word says.
- R8: A byte count above `MAX_BYTES` sets status bit 2 and halts the channel before any data is moved.
- R9: A link word that is not end-of-list and has any of bits 4:1 set causes the following, once that descriptor's copy is done: status bit 2 is set, the channel halts, and the current-descriptor register keeps that descriptor's address.
- R10: Writing 1 to mode bit 1 (abort, which reads 0), or clearing mode bit 0 while busy, halts the channel at the next access boundary. The channel then reports idle within a bounded number of cycles and issues no further requests.
- R11: An acknowledge with `memErr` high sets status bit 3 (transfer error) and halts the channel.
- R12: `irq` equals (mode bit 3 AND status bit 0) OR (mode bit 2 AND (status bit 2 OR status bit 3)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | 1 for a write access, 0 for a read |
| memAddr | output | 32 | Byte address of the access |
| memWrData | output | 32 | Write data |
| memAck | input | 1 | Access complete this cycle |
| memErr | input | 1 | Access failed, valid with memAck |
| memRdData | input | 32 | Read data, valid with memAck |
| irq | output | 1 | Channel interrupt |

## Verification
The bench goes after the length edges of a descriptor. A 6-byte count must move exactly two words and leave the next word untouched. A zero count must raise the programming error without copying, where a wrong design would issue a read with nothing to move. A count one word beyond the limit must halt before any write, where a wrong design would overrun the destination.

For restart, it rewrites an already-set start bit and expects no new copy, which catches a design that triggers on the level rather than the edge. It aborts a long copy partway and checks two things: the last destination word is never written, and the channel reports halted within a few cycles. A design that drains the whole descriptor fails the first check. A design that never reaches idle fails the second.

The bench also checks a misaligned link, an acknowledge carrying an error, and the write-one-to-clear status behaviour. Each of these must leave the flags and the current-descriptor address exactly where the requirements place them.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam logic [1:0] REG_MODE   = 2'd0;
  localparam logic [1:0] REG_STATUS = 2'd1;
  localparam logic [1:0] REG_CDAR   = 2'd2;
  localparam logic [1:0] REG_COUNT  = 2'd3;

  // status event bit positions
  localparam int EV_LIST = 0;
  localparam int EV_SEG  = 1;
  localparam int EV_PROG = 2;
  localparam int EV_XFER = 3;
  localparam int EV_NUM  = 4;

  // mode bit positions
  localparam int MD_START  = 0;
  localparam int MD_ABORT  = 1;
  localparam int MD_ERR_EN = 2;
  localparam int MD_EOL_EN = 3;

  localparam int DESC_ALIGN_BITS = 5;

  typedef enum logic [1:0] {SEL_DESC, SEL_SRC, SEL_DST} addr_sel_e;

  typedef struct packed {
    logic      cdarWr;
    logic      descLoad;
    logic [1:0] descIdx;
    logic      dataCapture;
    logic      beatStep;
    logic      linkStep;
    addr_sel_e addrSel;
  } dp_ctl_t;

  typedef struct packed {
    logic countZero;
    logic countOver;
    logic lastBeat;
    logic eol;
    logic nextBad;
  } dp_flag_t;

endpackage

// File: rtl/dma_seq_dpath.sv
module dma_seq_dpath
  import dma_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MAX_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [31:0]       regWrData,
  input  logic [31:0]       memRdData,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWrData,
  output logic [31:0]       cdarOut,
  output logic [CNT_W-1:0]  countOut,
  output dp_flag_t          flags
);

  localparam logic [CNT_W-1:0] WORD_BYTES = CNT_W'(4);
  localparam logic [CNT_W-1:0] MAX_CNT    = CNT_W'(MAX_BYTES);

  logic [31:0]      cdarQ, srcQ, dstQ, nextQ, bufQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] beatBytes;

  assign beatBytes = (cntQ >= WORD_BYTES) ? WORD_BYTES : cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cdarQ <= '0;
      srcQ  <= '0;
      dstQ  <= '0;
      nextQ <= '0;
      bufQ  <= '0;
      cntQ  <= '0;
    end else begin
      if (ctl.cdarWr)
        cdarQ <= {regWrData[31:DESC_ALIGN_BITS], {DESC_ALIGN_BITS{1'b0}}};
      else if (ctl.linkStep)
        cdarQ <= {nextQ[31:DESC_ALIGN_BITS], {DESC_ALIGN_BITS{1'b0}}};
      if (ctl.descLoad) begin
        unique case (ctl.descIdx)
          2'd0: srcQ  <= memRdData;
          2'd1: dstQ  <= memRdData;
          2'd2: nextQ <= memRdData;
          2'd3: cntQ  <= memRdData[CNT_W-1:0];
        endcase
      end
      if (ctl.dataCapture) bufQ <= memRdData;
      if (ctl.beatStep) begin
        srcQ <= srcQ + 32'd4;
        dstQ <= dstQ + 32'd4;
        cntQ <= cntQ - beatBytes;
      end
    end
  end

  always_comb begin
    unique case (ctl.addrSel)
      SEL_SRC: memAddr = srcQ;
      SEL_DST: memAddr = dstQ;
      default: memAddr = cdarQ + {28'd0, ctl.descIdx, 2'b00};
    endcase
  end

  assign memWrData       = bufQ;
  assign cdarOut         = cdarQ;
  assign countOut        = cntQ;
  assign flags.countZero = (cntQ == '0);
  assign flags.countOver = (cntQ > MAX_CNT);
  assign flags.lastBeat  = (cntQ <= WORD_BYTES);
  assign flags.eol       = nextQ[0];
  assign flags.nextBad   = |nextQ[DESC_ALIGN_BITS-1:1];

  // R9: the sequencer never follows a misaligned link
  p_link_aligned_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.linkStep |-> !flags.nextBad && !flags.eol);
  // R7: no data beat is committed for an empty descriptor
  p_no_empty_beat_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.beatStep |-> !flags.countZero);
  // R8: copying only happens for a legal length
  p_len_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dataCapture |-> !flags.countOver);

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic [31:0]        regWrData,
  input  logic               memAck,
  input  logic               memErr,
  input  dp_flag_t           flags,
  output dp_ctl_t            ctl,
  output logic               memReq,
  output logic               memWe,
  output logic               startQ,
  output logic               errIrqEnQ,
  output logic               eolIrqEnQ,
  output logic [EV_NUM-1:0]  eventQ,
  output logic               busyQ,
  output logic               haltedQ,
  output logic               irq
);

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE} state_e;

  state_e stateQ, stateD;
  logic [1:0] idxQ, idxD;
  logic haltPendQ;
  logic [EV_NUM-1:0] setEv;
  logic modeWr, statusWr, goStart, stopReq;
  logic finish, haltNow, doneNow;

  assign modeWr   = regWr && (regAddr == REG_MODE);
  assign statusWr = regWr && (regAddr == REG_STATUS);
  assign goStart  = modeWr && regWrData[MD_START] && !startQ && !busyQ;
  assign stopReq  = modeWr && busyQ && (regWrData[MD_ABORT] || !regWrData[MD_START]);

  always_comb begin
    stateD      = stateQ;
    idxD        = idxQ;
    ctl         = '0;
    ctl.descIdx = idxQ;
    ctl.addrSel = SEL_DESC;
    ctl.cdarWr  = regWr && (regAddr == REG_CDAR) && !busyQ;
    memReq      = 1'b0;
    memWe       = 1'b0;
    setEv       = '0;
    finish      = 1'b0;
    haltNow     = 1'b0;
    doneNow     = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (goStart) begin
          stateD = ST_FETCH;
          idxD   = 2'd0;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            setEv[EV_XFER] = 1'b1;
            haltNow        = 1'b1;
          end else begin
            ctl.descLoad = 1'b1;
            if (haltPendQ)        haltNow = 1'b1;
            else if (idxQ == 2'd3) stateD = ST_CHECK;
            else                   idxD   = idxQ + 2'd1;
          end
        end
      end
      ST_CHECK: begin
        if (flags.countZero) begin
          setEv[EV_PROG] = 1'b1;
          finish         = 1'b1;
        end else if (flags.countOver) begin
          setEv[EV_PROG] = 1'b1;
          haltNow        = 1'b1;
        end else if (haltPendQ) begin
          haltNow = 1'b1;
        end else begin
          stateD = ST_READ;
        end
      end
      ST_READ: begin
        memReq      = 1'b1;
        ctl.addrSel = SEL_SRC;
        if (memAck) begin
          if (memErr) begin
            setEv[EV_XFER] = 1'b1;
            haltNow        = 1'b1;
          end else begin
            ctl.dataCapture = 1'b1;
            if (haltPendQ) haltNow = 1'b1;
            else           stateD  = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        ctl.addrSel = SEL_DST;
        if (memAck) begin
          if (memErr) begin
            setEv[EV_XFER] = 1'b1;
            haltNow        = 1'b1;
          end else begin
            ctl.beatStep = 1'b1;
            if (flags.lastBeat) finish  = 1'b1;
            else if (haltPendQ) haltNow = 1'b1;
            else                stateD  = ST_READ;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
    if (finish) begin
      setEv[EV_SEG] = 1'b1;
      if (flags.eol) begin
        setEv[EV_LIST] = 1'b1;
        doneNow        = 1'b1;
      end else if (flags.nextBad) begin
        setEv[EV_PROG] = 1'b1;
        haltNow        = 1'b1;
      end else if (haltPendQ) begin
        haltNow = 1'b1;
      end else begin
        ctl.linkStep = 1'b1;
        stateD       = ST_FETCH;
        idxD         = 2'd0;
      end
    end
    if (haltNow || doneNow) stateD = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      idxQ      <= '0;
      haltPendQ <= 1'b0;
      busyQ     <= 1'b0;
      haltedQ   <= 1'b0;
      startQ    <= 1'b0;
      errIrqEnQ <= 1'b0;
      eolIrqEnQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      idxQ      <= idxD;
      haltPendQ <= (haltPendQ || stopReq) && !(haltNow || doneNow);
      if (goStart)                busyQ <= 1'b1;
      else if (haltNow || doneNow) busyQ <= 1'b0;
      if (goStart)      haltedQ <= 1'b0;
      else if (haltNow) haltedQ <= 1'b1;
      if (modeWr) begin
        startQ    <= regWrData[MD_START];
        errIrqEnQ <= regWrData[MD_ERR_EN];
        eolIrqEnQ <= regWrData[MD_EOL_EN];
      end
    end
  end

  for (genvar i = 0; i < EV_NUM; i++) begin : g_evbit
    always_ff @(posedge clk) begin
      if (!rstN) eventQ[i] <= 1'b0;
      else       eventQ[i] <= setEv[i] || (eventQ[i] && !(statusWr && regWrData[i]));
    end
  end

  assign irq = (eolIrqEnQ && eventQ[EV_LIST]) ||
               (errIrqEnQ && (eventQ[EV_PROG] || eventQ[EV_XFER]));

  // cycles spent waiting for a requested halt
  logic [6:0] haltWaitQ;
  always_ff @(posedge clk) begin
    if (!rstN)                    haltWaitQ <= '0;
    else if (haltPendQ && busyQ)  haltWaitQ <= haltWaitQ + 7'd1;
    else                          haltWaitQ <= '0;
  end

  // R2: a request is held until acknowledged
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe));
  // R3: memory is touched only while busy
  p_req_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busyQ && !haltedQ);
  // R5: normal completion leaves start set
  p_start_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) && !haltedQ && !$past(modeWr) |-> startQ);
  // R10: a halt request is honoured within a bounded window (acknowledged memory)
  p_halt_bounded_r10: assert property (@(posedge clk) disable iff (!rstN)
    haltWaitQ < 7'd64);
  // R11: an errored acknowledge halts the channel
  p_err_halts_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && memErr |=> !busyQ && haltedQ && eventQ[EV_XFER]);

endmodule

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
  import dma_seq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MAX_BYTES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWrData,
  input  logic        memAck,
  input  logic        memErr,
  input  logic [31:0] memRdData,
  output logic        irq
);

  dp_ctl_t           ctl;
  dp_flag_t          flags;
  logic [31:0]       cdar;
  logic [CNT_W-1:0]  count;
  logic              startQ, errIrqEnQ, eolIrqEnQ, busyQ, haltedQ;
  logic [EV_NUM-1:0] eventQ;

  dma_seq_ctrl u_ctrl (
    .clk, .rstN, .regWr, .regAddr, .regWrData, .memAck, .memErr,
    .flags, .ctl, .memReq, .memWe, .startQ, .errIrqEnQ, .eolIrqEnQ,
    .eventQ, .busyQ, .haltedQ, .irq
  );

  dma_seq_dpath #(.CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)) u_dpath (
    .clk, .rstN, .ctl, .regWrData, .memRdData, .memAddr, .memWrData,
    .cdarOut(cdar), .countOut(count), .flags
  );

  always_comb begin
    unique case (regAddr)
      REG_MODE:   regRdData = {28'd0, eolIrqEnQ, errIrqEnQ, 1'b0, startQ};
      REG_STATUS: regRdData = {26'd0, haltedQ, busyQ, eventQ};
      REG_CDAR:   regRdData = cdar;
      default:    regRdData = 32'(count);
    endcase
  end

endmodule

// File: tb/dma_seq_chan_test.sv
module dma_seq_chan_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWrData;
  logic        memAck = 1'b0;
  logic        memErr = 1'b0;
  logic [31:0] memRdData = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [256];
  logic        errArm = 1'b0;
  logic [31:0] errAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_seq_chan uut (
    .clk, .rstN, .regWr, .regAddr, .regWrData, .regRdData,
    .memReq, .memWe, .memAddr, .memWrData, .memAck, .memErr, .memRdData, .irq
  );

  // memory model: acknowledge one cycle after a request is seen
  always @(posedge clk) begin
    if (memAck) begin
      memAck <= 1'b0;
      memErr <= 1'b0;
      if (memReq && memWe && !memErr) mem[memAddr[9:2]] <= memWrData;
    end else if (memReq) begin
      memAck    <= 1'b1;
      memRdData <= mem[memAddr[9:2]];
      memErr    <= errArm && (memAddr == errAddr);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regW(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regR(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      regR(2'd1, s);
      if (!s[4] || s[5]) return;
    end
    check({tag, " idle timeout"}, 32'd1, 32'd0);
  endtask

  task automatic setDesc(input int base, input int src, input int dst, input int nxt, input int cnt);
    mem[base/4]     = src;
    mem[base/4 + 1] = dst;
    mem[base/4 + 2] = nxt;
    mem[base/4 + 3] = cnt;
  endtask

  task automatic run(input int desc, input logic [3:0] en, input string tag);
    regW(2'd0, 32'h0);
    regW(2'd1, 32'hF);
    regW(2'd2, desc);
    regW(2'd0, {28'd0, en[3:2], 2'b01});
    waitIdle(tag);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      regR(2'(i), d);
      check("R1 register reset", d, 32'h0);
    end
    check("R1 irq reset", {31'd0, irq}, 32'd0);
    check("R1 memReq reset", {31'd0, memReq}, 32'd0);
  endtask

  task automatic t_single;
    logic [31:0] d;
    setDesc(32'h000, 32'h200, 32'h300, 32'h1, 6);
    mem[32'h200/4] = 32'hA1A1A1A1; mem[32'h204/4] = 32'hA2A2A2A2;
    mem[32'h300/4] = 0; mem[32'h304/4] = 0; mem[32'h308/4] = 32'h5EE5;
    run(32'h000, 4'b1000, "R2");
    check("R2 word0 copied", mem[32'h300/4], 32'hA1A1A1A1);
    check("R2 partial word copied", mem[32'h304/4], 32'hA2A2A2A2);
    check("R2 no overrun", mem[32'h308/4], 32'h5EE5);
    regR(2'd1, d);
    check("R3 status after done", d, 32'h3);
    regR(2'd3, d);
    check("R4 count zero", d, 32'h0);
    check("R12 eol irq", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_chain;
    logic [31:0] d;
    setDesc(32'h020, 32'h240, 32'h310, 32'h040, 8);
    setDesc(32'h040, 32'h250, 32'h320, 32'h060, 16);
    setDesc(32'h060, 32'h270, 32'h340, 32'h1, 4);
    for (int i = 0; i < 8; i++) mem[32'h240/4 + i] = 32'hC000 + i;
    for (int i = 0; i < 12; i++) mem[32'h310/4 + i] = 0;
    run(32'h020, 4'b0000, "R4");
    check("R4 d0 w0", mem[32'h310/4], 32'hC000);
    check("R4 d0 w1", mem[32'h314/4], 32'hC001);
    check("R4 d1 w0", mem[32'h320/4], 32'hC004);
    check("R4 d1 w3", mem[32'h32C/4], 32'hC007);
    check("R4 d2 w0", mem[32'h340/4], mem[32'h270/4]);
    regR(2'd2, d);
    check("R4 cdar at last desc", d, 32'h060);
    regR(2'd1, d);
    check("R4 status list+seg", d, 32'h3);
    check("R12 irq masked", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_restart;
    logic [31:0] d;
    regR(2'd0, d);
    check("R5 start kept", d & 32'h1, 32'h1);
    regW(2'd1, 32'hF);
    mem[32'h340/4] = 32'h0;
    regW(2'd0, 32'h1);
    repeat (20) @(negedge clk);
    check("R5 rewrite no restart", mem[32'h340/4], 32'h0);
    regR(2'd1, d);
    check("R5 rewrite status untouched", d, 32'h0);
    regW(2'd0, 32'h0);
    regW(2'd0, 32'h1);
    waitIdle("R5");
    check("R5 clear then set restarts", mem[32'h340/4], mem[32'h270/4]);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    regW(2'd1, 32'h0);
    regR(2'd1, d);
    check("R6 zero write keeps", d, 32'h3);
    regW(2'd1, 32'h1);
    regR(2'd1, d);
    check("R6 clear one bit", d, 32'h2);
  endtask

  task automatic t_null;
    logic [31:0] d;
    setDesc(32'h080, 32'h200, 32'h3F0, 32'h1, 0);
    mem[32'h3F0/4] = 32'h77;
    run(32'h080, 4'b0100, "R7");
    regR(2'd1, d);
    check("R7 prog+seg+list", d, 32'h7);
    regR(2'd3, d);
    check("R7 count reads zero", d, 32'h0);
    check("R7 no copy", mem[32'h3F0/4], 32'h77);
    check("R12 error irq", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_over(input logic [3:0] en, input logic expIrq);
    logic [31:0] d;
    setDesc(32'h0A0, 32'h200, 32'h3E0, 32'h1, 68);
    mem[32'h3E0/4] = 32'h99;
    run(32'h0A0, en, "R8");
    regR(2'd1, d);
    check("R8 prog and halted", d, 32'h24);
    check("R8 no copy", mem[32'h3E0/4], 32'h99);
    check("R12 irq per enable", {31'd0, irq}, {31'd0, expIrq});
  endtask

  task automatic t_badlink;
    logic [31:0] d;
    setDesc(32'h0C0, 32'h200, 32'h3D0, 32'h0E8, 4);
    mem[32'h3D0/4] = 0;
    run(32'h0C0, 4'b0000, "R9");
    check("R9 copy done first", mem[32'h3D0/4], mem[32'h200/4]);
    regR(2'd1, d);
    check("R9 prog seg halted", d, 32'h26);
    regR(2'd2, d);
    check("R9 cdar kept", d, 32'h0C0);
  endtask

  task automatic t_abort(input logic useAbort);
    logic [31:0] d;
    logic seenIdle;
    setDesc(32'h100, 32'h200, 32'h380, 32'h1, 64);
    mem[32'h3BC/4] = 32'hDEAD;
    regW(2'd0, 32'h0);
    regW(2'd1, 32'hF);
    regW(2'd2, 32'h100);
    regW(2'd0, 32'h1);
    repeat (20) @(negedge clk);
    regR(2'd1, d);
    check("R3 busy mid copy", d & 32'h30, 32'h10);
    regW(2'd0, useAbort ? 32'h3 : 32'h0);
    seenIdle = 1'b0;
    for (int i = 0; i < 8; i++) begin
      regR(2'd1, d);
      if (d[5]) seenIdle = 1'b1;
      @(negedge clk);
    end
    check("R10 halted in bound", {31'd0, seenIdle}, 32'd1);
    check("R10 no request after halt", {31'd0, memReq}, 32'd0);
    check("R10 tail not written", mem[32'h3BC/4], 32'hDEAD);
    regR(2'd0, d);
    check("R10 abort reads zero", d & 32'h2, 32'h0);
  endtask

  task automatic t_memerr;
    logic [31:0] d;
    setDesc(32'h0E0, 32'h280, 32'h3C0, 32'h1, 8);
    errAddr = 32'h3C4;
    errArm  = 1'b1;
    run(32'h0E0, 4'b0100, "R11");
    errArm  = 1'b0;
    regR(2'd1, d);
    check("R11 xfer and halted", d, 32'h28);
    check("R12 irq on xfer", {31'd0, irq}, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h1000 + i;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_restart();
    run(32'h000, 4'b0000, "R6");
    t_w1c();
    t_null();
    t_over(4'b0100, 1'b1);
    t_over(4'b0000, 1'b0);
    t_badlink();
    t_abort(1'b1);
    t_abort(1'b0);
    t_memerr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule